// File: doc/BRIEF.md
# Pipelined Synchronous Byte-Write Static Memory

This block is a single-clock static memory that holds a parameterized number of 32-bit words. Each word is split into four 8-bit byte lanes. The address, the write data and every control input are captured in a register on the rising clock edge. The write to the array then finishes on the next edge without further help from outside. Read data passes through a second register, so a read issued at one edge shows up on the output one edge later, together with a valid flag.

A write changes one to four lanes of the addressed word. There are two ways to choose them. A lane is written when its own active-low lane enable and the active-low byte-write enable are both low. An active-low global write forces all four lanes. Three chip selects, two active-low and one active-high, let several of these blocks share one address space. The block responds only when all three are active.

The word address comes from an external burst address unit. A pad-level shared data bus is split here into separate write and read ports.

Top module: `sram_pipe`

## Requirements
- R1: Inputs are captured at a rising edge N. For a read captured at edge N, `rd_data` holds the addressed word and `rd_valid` is 1 after edge N+1.
- R2: The block is selected only when `sel0_n`=0, `sel1`=1 and `sel2_n`=0. A cycle captured without selection writes nothing. It also drives `rd_valid`=0 one edge later.
- R3: With `gw_n`=1 and `bw_n`=0, lane i (`wr_data` bits 8i+7:8i, where lane 0 is bits 7:0) is written exactly when `be_n[i]`=0.
- R4: `gw_n`=0 writes all four lanes of the word, whatever `bw_n` and `be_n` are.
- R5: Lanes that a write does not select keep their previous contents. So does every word that is not addressed.
- R6: A selected cycle that writes no lane is a read and changes nothing in the array. This is the case when `gw_n`=1 and either `bw_n`=1 or `be_n`=4'b1111.
- R7: After a write or a deselected cycle has passed through the pipeline, `rd_valid`=0 and `rd_data`=0.
- R8: A synchronous reset (`rst_n`=0 at an edge) sets `rd_valid`=0 and `rd_data`=0.
- R9: A word written by the cycle captured at edge N is returned by a read captured at edge N+1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | AW | Word address from the burst address unit |
| wr_data | input | 32 | Write data, four byte lanes |
| sel0_n | input | 1 | Chip select, active low |
| sel1 | input | 1 | Chip select, active high |
| sel2_n | input | 1 | Chip select, active low |
| gw_n | input | 1 | Global write of all lanes, active low |
| bw_n | input | 1 | Byte-write enable, active low |
| be_n | input | 4 | Per-lane write enables, active low |
| rd_data | output | 32 | Registered read data, zero when not valid |
| rd_valid | output | 1 | High when rd_data carries a read result |

## Verification
The assertions check on every cycle that:
- a read appears two edges after it is presented at the ports, and a write or a deselected cycle never raises the valid flag;
- the output is zero whenever it is not valid;
- a global write always reaches all four lanes;
- a lane that is not being written keeps its stored byte at the addressed location.

Only the bench scenarios can show the rest:
- that the right lanes of the right word hold the right bytes after a mix of lane writes;
- that a blocked write caused by a single inactive chip select leaves the data intact;
- that a write followed at once by a read of the same word returns the new data.

// File: rtl/sram_pkg.sv
// Package: shared sizes and the lane write-mask decode for the
// pipelined byte-write memory. Assumes four 8-bit lanes per word.
package sram_pkg;
    localparam int LANES  = 4;
    localparam int LANE_W = 8;
    localparam int WORD_W = LANES * LANE_W;

    typedef logic [LANES-1:0] lane_mask_t;

    // Lanes to write: global write wins, else gated per-lane enables.
    function automatic lane_mask_t write_mask(input logic gw_n,
                                              input logic bw_n,
                                              input lane_mask_t be_n);
        if (!gw_n)
            return '1;
        else if (!bw_n)
            return ~be_n;
        else
            return '0;
    endfunction
endpackage

// File: rtl/sram_in_stage.sv
// Input capture stage: registers address, data and decoded control at
// the rising edge. Assumes selection needs all three chip selects active.
module sram_in_stage
    import sram_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              gw_n,
    input  logic              bw_n,
    input  lane_mask_t        be_n,
    output logic [AW-1:0]     s_addr,
    output logic [WORD_W-1:0] s_data,
    output lane_mask_t        s_mask,
    output logic              s_rd,
    output logic              s_wr
);
    logic       chip_on;
    lane_mask_t mask_now;

    // Decode selection and the lanes requested this cycle.
    always_comb begin
        chip_on  = !sel0_n && sel1 && !sel2_n;
        mask_now = write_mask(gw_n, bw_n, be_n);
    end

    // Capture all inputs; the access kind is cleared on reset.
    always_ff @(posedge clk) begin
        s_addr <= addr;
        s_data <= wr_data;
        s_mask <= mask_now;
        if (!rst_n) begin
            s_rd <= 1'b0;
            s_wr <= 1'b0;
        end else begin
            s_rd <= chip_on && (mask_now == '0);
            s_wr <= chip_on && (mask_now != '0);
        end
    end

    AST_GLOBAL_ALL_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel0_n && sel1 && !sel2_n && !gw_n) |=> (s_wr && s_mask == '1 && !s_rd)); // R4
    AST_DESELECT_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (sel0_n || !sel1 || sel2_n) |=> (!s_wr && !s_rd)); // R2
endmodule

// File: rtl/sram_lane.sv
// One byte lane: storage array with a registered read output.
// Assumes the write and the read come from the input stage's registers.
module sram_lane #(
    parameter int DEPTH = 256,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] s_addr,
    input  logic [W-1:0]  s_byte,
    input  logic          s_we,
    input  logic          s_rd,
    output logic [W-1:0]  q
);
    logic [W-1:0] mem [DEPTH];

    // Self-timed write: commit the captured byte one edge after capture.
    always_ff @(posedge clk) begin
        if (s_we)
            mem[s_addr] <= s_byte;
    end

    // Output register: read result when reading, zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= '0;
        else if (s_rd)
            q <= mem[s_addr];
        else
            q <= '0;
    end

    AST_LANE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !s_we |=> (mem[$past(s_addr)] === $past(mem[s_addr]))); // R5
endmodule

// File: rtl/sram_pipe.sv
// Top: pipelined byte-write static memory. It captures inputs, writes the
// selected lanes, and returns read data with a valid flag one edge later.
// Assumes DEPTH is a power of two.
module sram_pipe
    import sram_pkg::*;
#(
    parameter int DEPTH = 256,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              sel0_n,
    input  logic              sel1,
    input  logic              sel2_n,
    input  logic              gw_n,
    input  logic              bw_n,
    input  logic [LANES-1:0]  be_n,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);
    logic [AW-1:0]     s_addr;
    logic [WORD_W-1:0] s_data;
    lane_mask_t        s_mask;
    logic              s_rd;
    logic              s_wr;

    sram_in_stage #(.AW(AW)) u_in (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .gw_n(gw_n), .bw_n(bw_n), .be_n(be_n),
        .s_addr(s_addr), .s_data(s_data), .s_mask(s_mask),
        .s_rd(s_rd), .s_wr(s_wr)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        sram_lane #(.DEPTH(DEPTH), .W(LANE_W)) u_lane (
            .clk(clk), .rst_n(rst_n), .s_addr(s_addr),
            .s_byte(s_data[i*LANE_W +: LANE_W]),
            .s_we(s_wr && s_mask[i]), .s_rd(s_rd),
            .q(rd_data[i*LANE_W +: LANE_W])
        );
    end

    // Valid flag follows the captured read by one edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_valid <= 1'b0;
        else
            rd_valid <= s_rd;
    end

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_valid |-> (rd_data == '0)); // R7
    AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel0_n && sel1 && !sel2_n && gw_n && (bw_n || (&be_n))) |-> ##2 rd_valid); // R1
    AST_WRITE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (!gw_n || (!bw_n && !(&be_n))) |-> ##2 !rd_valid); // R7
endmodule

// File: tb/sram_pipe_test.sv
// Scoreboard bench: the drive task predicts each cycle's output and
// queues it; the monitor pops and compares two edges later.
module sram_pipe_test;
    localparam int DEPTH = 256;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [31:0]   wr_data = '0;
    logic          sel0_n = 1'b1, sel1 = 1'b0, sel2_n = 1'b1;
    logic          gw_n = 1'b1, bw_n = 1'b1;
    logic [3:0]    be_n = 4'hF;
    logic [31:0]   rd_data;
    logic          rd_valid;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    logic [31:0] model [DEPTH];

    typedef struct {
        logic        v;
        logic [31:0] d;
        int          due;
        string       tag;
    } exp_t;
    exp_t sb[$];

    sram_pipe #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_data(wr_data),
        .sel0_n(sel0_n), .sel1(sel1), .sel2_n(sel2_n),
        .gw_n(gw_n), .bw_n(bw_n), .be_n(be_n),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Drive one cycle at the falling edge and push the predicted result.
    task automatic drive(input logic s0n, input logic s1, input logic s2n,
                         input logic g, input logic b, input logic [3:0] e,
                         input logic [AW-1:0] a, input logic [31:0] d,
                         input string tag);
        exp_t it;
        logic [3:0] m;
        @(negedge clk);
        sel0_n = s0n; sel1 = s1; sel2_n = s2n;
        gw_n = g; bw_n = b; be_n = e; addr = a; wr_data = d;
        m = !g ? 4'hF : (!b ? ~e : 4'h0);
        it.due = cyc + 2;
        it.tag = tag;
        if (!s0n && s1 && !s2n && m != 0) begin
            for (int i = 0; i < 4; i++)
                if (m[i]) model[a][i*8 +: 8] = d[i*8 +: 8];
            it.v = 1'b0; it.d = '0;
        end else if (!s0n && s1 && !s2n) begin
            it.v = 1'b1; it.d = model[a];
        end else begin
            it.v = 1'b0; it.d = '0;
        end
        sb.push_back(it);
    endtask

    task automatic wr_all(input logic [AW-1:0] a, input logic [31:0] d, input string t);
        drive(0, 1, 0, 0, 1, 4'hF, a, d, t);
    endtask
    task automatic rd(input logic [AW-1:0] a, input string t);
        drive(0, 1, 0, 1, 1, 4'hF, a, 32'h0, t);
    endtask

    // Monitor: compare each queued prediction in its due cycle.
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].due == cyc) begin
            exp_t it;
            it = sb.pop_front();
            checks++;
            if (rd_valid !== it.v || rd_data !== it.d) begin
                fails++;
                $display("FAIL %s: got valid=%0b data=%h, expected valid=%0b data=%h",
                         it.tag, rd_valid, rd_data, it.v, it.d);
            end
        end
    end

    initial begin
        #800000;
        fails++;
        $display("FAIL watchdog: got hung run, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;  // R8 reset state
        if (rd_valid !== 1'b0 || rd_data !== 32'h0) begin
            fails++;
            $display("FAIL R8: got valid=%0b data=%h, expected valid=0 data=00000000",
                     rd_valid, rd_data);
        end
        rst_n = 1'b1;
        // R4: global write ignores be_n/bw_n; R1: read back with latency
        for (int i = 0; i < 8; i++) wr_all(AW'(i), 32'hA5A50000 + 32'(i * 32'h1111), "R4");
        drive(0, 1, 0, 0, 0, 4'hE, 8'd9, 32'h0BADF00D, "R4");
        for (int i = 0; i < 8; i++) rd(AW'(i), "R1");
        rd(8'd9, "R4");
        // R3/R5: single-lane writes on word 3, each read back
        for (int i = 0; i < 4; i++) begin
            drive(0, 1, 0, 1, 0, ~(4'b1 << i), 8'd3, 32'h11223344 << (i * 2), "R3");
            rd(8'd3, "R5");
        end
        drive(0, 1, 0, 1, 0, 4'b1010, 8'd4, 32'hDEADBEEF, "R3");
        rd(8'd4, "R3");
        // R6: enables without bw_n, and bw_n without enables, are reads
        drive(0, 1, 0, 1, 1, 4'h0, 8'd5, 32'hFFFFFFFF, "R6");
        drive(0, 1, 0, 1, 0, 4'hF, 8'd5, 32'hFFFFFFFF, "R6");
        rd(8'd5, "R6");
        // R2/R7: each select inactive blocks a global write
        drive(1, 1, 0, 0, 1, 4'hF, 8'd6, 32'h12345678, "R2");
        drive(0, 0, 0, 0, 1, 4'hF, 8'd6, 32'h12345678, "R2");
        drive(0, 1, 1, 0, 1, 4'hF, 8'd6, 32'h12345678, "R7");
        rd(8'd6, "R2");
        // R9: write then read same word back to back, including top address
        wr_all(8'd7, 32'hCAFEF00D, "R9");
        rd(8'd7, "R9");
        wr_all(AW'(DEPTH - 1), 32'h87654321, "R9");
        drive(0, 1, 0, 1, 0, 4'b0111, AW'(DEPTH - 1), 32'hFF000000, "R3");
        rd(AW'(DEPTH - 1), "R9");
        // flush with deselected cycles
        for (int i = 0; i < 3; i++) drive(1, 0, 1, 1, 1, 4'hF, 8'd0, 32'h0, "R7");
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule